// File: doc/BRIEF.md
# Streaming Coprocessor Instruction Decoder

This block turns a stream of 16-bit instruction words into decoded records for a small 32-bit RISC coprocessor. The coprocessor comes in two variants, a graphics-oriented one and a signal-processing one, and the `dsp_mode` input selects which one to decode for. Words enter on a valid/ready handshake, each with its own byte address. Every instruction produces exactly one record on a second valid/ready handshake. The record holds an opcode class, both 5-bit fields of the word, the resolved immediate, the condition code and the branch target of a relative jump.

The 6-bit primary opcode sits in bits 15:10. The first 5-bit field sits in bits 9:5 and the second in bits 4:0. Classes 0 to 63 equal the primary opcode number. The classes above 63 mark the meanings that exist in only one variant. The move-immediate instruction (opcode 38) takes its 32-bit constant from the two words after it. The block gathers those words before it issues the record. A synchronous reset drops any instruction that is only partly gathered.

Top module: `rinsn_decoder`

## Requirements
- R1: The record's class is the primary opcode `in_word[15:10]` unless a rule below remaps it. `out_ra` is `in_word[9:5]` and `out_rb` is `in_word[4:0]` for every instruction.
- R2: With `dsp_mode`=0, opcode 63 with `in_word[5]`=1 gives class 64 (unpack). With `in_word[5]`=0 it gives class 63.
- R3: With `dsp_mode`=1, opcodes 32, 33, 42, 48 and 63 give classes 65, 66, 67, 68 and 69 respectively, whatever the value of `in_word[5]`. All other opcodes keep their number as class.
- R4: Opcodes 2, 3, 6, 7, 24, 25, 27 and 29 give `out_imm` = field 9:5, except that a field value of 0 gives 32.
- R5: Classes 65 and 69 follow the same 1-to-32 rule. Opcodes 32 and 63 decoded with `dsp_mode`=0 give `out_imm`=0.
- R6: Opcodes 13, 14, 15 and 35 give `out_imm` = field 9:5 unchanged, from 0 to 31.
- R7: Every class that R4 to R10 do not name gives `out_imm`=0, `out_cond`=0 and `out_target`=0.
- R8: Opcode 38 consumes the next two accepted words. The first word forms `out_imm[15:0]` and the second forms `out_imm[31:16]`. The block emits one record, of class 38, and only after the second word. `out_rb` holds the destination register.
- R9: Opcode 53 (relative jump) gives `out_cond` = bits 4:0 and `out_target` = `in_addr` + 2 + the sign-extended 5-bit field 9:5, computed modulo 2^32. Its `out_imm` is 0.
- R10: Opcode 52 (absolute jump) gives `out_cond` = bits 4:0 and `out_target`=0. The register that holds the target appears on `out_ra`.
- R11: While `out_valid`=1 and `out_ready`=0, the record stays unchanged and `in_ready` is 0 outside a gather. Each accepted record is presented exactly once.
- R12: While words of an immediate are being gathered, `in_ready`=1 and `out_valid`=0, even when `out_ready`=0.
- R13: A synchronous `rst` clears `out_valid`, abandons any partial gather and raises `in_ready`, so that the next word is decoded as an opcode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| dsp_mode | input | 1 | 1 selects the signal-processing variant; sampled with each opcode word |
| in_valid | input | 1 | Input word valid |
| in_ready | output | 1 | Block accepts a word this cycle |
| in_word | input | 16 | Instruction or immediate word |
| in_addr | input | 32 | Byte address of `in_word` |
| out_valid | output | 1 | Decoded record valid |
| out_ready | input | 1 | Consumer accepts the record |
| out_class | output | 7 | Opcode class |
| out_ra | output | 5 | Field 9:5 |
| out_rb | output | 5 | Field 4:0 |
| out_imm | output | 32 | Resolved immediate |
| out_cond | output | 5 | Condition code of jumps |
| out_target | output | 32 | Relative-jump target |

## Verification
The decode is exercised with the same opcode numbers in both variants. This separates a remapped class from one that was kept, and it shows whether bit 5 affects only graphics opcode 63. Quick fields of 0, a middle value and 31 distinguish the 1-to-32 rule from the literal rule. Relative jumps with positive, negative, extreme and wrapping offsets test the sign extension and the carry of the target add. Directed runs stall the consumer during and after a move-immediate gather, and assert reset in the middle of one.

// File: rtl/rinsn_decoder.sv
module rinsn_decoder (
  input  logic        clk,
  input  logic        rst,
  input  logic        dsp_mode,
  input  logic        in_valid,
  output logic        in_ready,
  input  logic [15:0] in_word,
  input  logic [31:0] in_addr,
  output logic        out_valid,
  input  logic        out_ready,
  output logic [6:0]  out_class,
  output logic [4:0]  out_ra,
  output logic [4:0]  out_rb,
  output logic [31:0] out_imm,
  output logic [4:0]  out_cond,
  output logic [31:0] out_target
);

  localparam logic [6:0] C_ADDQ    = 7'd2,  C_ADDQT  = 7'd3,  C_SUBQ  = 7'd6,  C_SUBQT = 7'd7;
  localparam logic [6:0] C_BTST    = 7'd13, C_BSET   = 7'd14, C_BCLR  = 7'd15;
  localparam logic [6:0] C_SHLQ    = 7'd24, C_SHRQ   = 7'd25, C_SHARQ = 7'd27, C_RORQ  = 7'd29;
  localparam logic [6:0] C_MOVEQ   = 7'd35, C_MOVEI  = 7'd38, C_JUMP  = 7'd52, C_JR    = 7'd53;
  localparam logic [6:0] C_UNPACK  = 7'd64, C_SUBQMD = 7'd65, C_SAT16S = 7'd66;
  localparam logic [6:0] C_SAT32S  = 7'd67, C_MIRROR = 7'd68, C_ADDQMD = 7'd69;

  typedef enum logic [1:0] {S_OP, S_LO, S_HI} gather_t;
  gather_t st;

  wire [5:0] op = in_word[15:10];
  wire [4:0] f1 = in_word[9:5];
  wire [4:0] f2 = in_word[4:0];

  logic [6:0]  d_class;
  logic [31:0] d_imm, d_tgt;
  logic [4:0]  d_cond;

  always_comb begin
    d_class = {1'b0, op};
    if (dsp_mode) begin
      case (op)
        6'd32:   d_class = C_SUBQMD;
        6'd33:   d_class = C_SAT16S;
        6'd42:   d_class = C_SAT32S;
        6'd48:   d_class = C_MIRROR;
        6'd63:   d_class = C_ADDQMD;
        default: ;
      endcase
    end else if (op == 6'd63 && in_word[5]) begin
      d_class = C_UNPACK;
    end
    d_imm  = '0;
    d_cond = '0;
    d_tgt  = '0;
    case (d_class)
      C_ADDQ, C_ADDQT, C_SUBQ, C_SUBQT, C_SHLQ, C_SHRQ, C_SHARQ, C_RORQ, C_SUBQMD, C_ADDQMD:
        d_imm = (f1 == 5'd0) ? 32'd32 : {27'd0, f1};
      C_BTST, C_BSET, C_BCLR, C_MOVEQ:
        d_imm = {27'd0, f1};
      C_JUMP:
        d_cond = f2;
      C_JR: begin
        d_cond = f2;
        d_tgt  = in_addr + 32'd2 + {{27{f1[4]}}, f1};
      end
      default: ;
    endcase
  end

  assign in_ready = (st != S_OP) || !out_valid || out_ready;
  wire take = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= S_OP;
      out_valid <= 1'b0;
    end else begin
      if (out_valid && out_ready) out_valid <= 1'b0;
      if (take) begin
        case (st)
          S_OP: begin
            out_class  <= d_class;
            out_ra     <= f1;
            out_rb     <= f2;
            out_imm    <= d_imm;
            out_cond   <= d_cond;
            out_target <= d_tgt;
            if (d_class == C_MOVEI) st <= S_LO;
            else out_valid <= 1'b1;
          end
          S_LO: begin
            out_imm[15:0] <= in_word;
            st <= S_HI;
          end
          S_HI: begin
            out_imm[31:16] <= in_word;
            out_valid <= 1'b1;
            st <= S_OP;
          end
          default: st <= S_OP;
        endcase
      end
    end
  end

  // R11
  hold_stable_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |=> out_valid && $stable(out_class) && $stable(out_imm)
                                && $stable(out_target) && $stable(out_cond));

  // R12
  gather_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (st != S_OP) |-> !out_valid);

  // R4
  quick_range_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid && (out_class == C_ADDQ || out_class == C_SHARQ || out_class == C_RORQ)
      |-> out_imm != 32'd0 && out_imm <= 32'd32);

  // R8
  movei_done_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(out_valid) && out_class == C_MOVEI |-> $past(st) == S_HI);

  // R13
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> !out_valid && st == S_OP);

endmodule

// File: tb/rinsn_decoder_tb.sv
module rinsn_decoder_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 24;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        dsp_mode = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [15:0] in_word = '0;
  logic [31:0] in_addr = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [6:0]  out_class;
  logic [4:0]  out_ra, out_rb, out_cond;
  logic [31:0] out_imm, out_target;

  int nchk = 0;
  int nbad = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rinsn_decoder u_dut (
    .clk(clk), .rst(rst), .dsp_mode(dsp_mode), .in_valid(in_valid), .in_ready(in_ready),
    .in_word(in_word), .in_addr(in_addr), .out_valid(out_valid), .out_ready(out_ready),
    .out_class(out_class), .out_ra(out_ra), .out_rb(out_rb), .out_imm(out_imm),
    .out_cond(out_cond), .out_target(out_target)
  );

  // mode, op, f1, f2, addr, class, imm, cond, target
  localparam logic [124:0] VEC [0:NV-1] = '{
    {1'b0, 6'd0,  5'd3,  5'd4, 32'h0,        7'd0,  32'd0,  5'd0, 32'h0},
    {1'b0, 6'd2,  5'd0,  5'd7, 32'h0,        7'd2,  32'd32, 5'd0, 32'h0},
    {1'b0, 6'd2,  5'd5,  5'd7, 32'h0,        7'd2,  32'd5,  5'd0, 32'h0},
    {1'b0, 6'd29, 5'd31, 5'd1, 32'h0,        7'd29, 32'd31, 5'd0, 32'h0},
    {1'b0, 6'd27, 5'd0,  5'd30,32'h0,        7'd27, 32'd32, 5'd0, 32'h0},
    {1'b0, 6'd35, 5'd0,  5'd6, 32'h0,        7'd35, 32'd0,  5'd0, 32'h0},
    {1'b0, 6'd15, 5'd31, 5'd6, 32'h0,        7'd15, 32'd31, 5'd0, 32'h0},
    {1'b0, 6'd63, 5'd0,  5'd2, 32'h0,        7'd63, 32'd0,  5'd0, 32'h0},
    {1'b0, 6'd63, 5'd1,  5'd2, 32'h0,        7'd64, 32'd0,  5'd0, 32'h0},
    {1'b1, 6'd63, 5'd1,  5'd2, 32'h0,        7'd69, 32'd1,  5'd0, 32'h0},
    {1'b1, 6'd63, 5'd0,  5'd2, 32'h0,        7'd69, 32'd32, 5'd0, 32'h0},
    {1'b1, 6'd32, 5'd0,  5'd3, 32'h0,        7'd65, 32'd32, 5'd0, 32'h0},
    {1'b0, 6'd32, 5'd0,  5'd3, 32'h0,        7'd32, 32'd0,  5'd0, 32'h0},
    {1'b1, 6'd33, 5'd4,  5'd5, 32'h0,        7'd66, 32'd0,  5'd0, 32'h0},
    {1'b1, 6'd42, 5'd4,  5'd5, 32'h0,        7'd67, 32'd0,  5'd0, 32'h0},
    {1'b1, 6'd48, 5'd4,  5'd5, 32'h0,        7'd68, 32'd0,  5'd0, 32'h0},
    {1'b1, 6'd0,  5'd4,  5'd5, 32'h0,        7'd0,  32'd0,  5'd0, 32'h0},
    {1'b1, 6'd2,  5'd0,  5'd5, 32'h0,        7'd2,  32'd32, 5'd0, 32'h0},
    {1'b0, 6'd53, 5'd31, 5'd2, 32'h1000,     7'd53, 32'd0,  5'd2, 32'h1001},
    {1'b0, 6'd53, 5'd15, 5'd1, 32'h20,       7'd53, 32'd0,  5'd1, 32'h31},
    {1'b1, 6'd53, 5'd16, 5'd3, 32'h100,      7'd53, 32'd0,  5'd3, 32'hF2},
    {1'b0, 6'd53, 5'd1,  5'd0, 32'hFFFFFFFE, 7'd53, 32'd0,  5'd0, 32'h1},
    {1'b0, 6'd52, 5'd7,  5'd4, 32'h1234,     7'd52, 32'd0,  5'd4, 32'h0},
    {1'b0, 6'd13, 5'd9,  5'd8, 32'h0,        7'd13, 32'd9,  5'd0, 32'h0}
  };

  string VREQ [0:NV-1] = '{
    "R1 R7", "R4", "R4", "R4", "R4", "R6", "R6", "R2", "R2", "R3 R5", "R3 R5", "R3 R5",
    "R5", "R3", "R3", "R3", "R3", "R3 R4", "R9", "R9", "R9", "R9", "R10", "R6"
  };

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nbad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic send(input logic mode, input logic [15:0] w, input logic [31:0] a);
    @(negedge clk);
    dsp_mode = mode;
    in_word  = w;
    in_addr  = a;
    in_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nbad);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    nchk++;
    nbad++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R13 reset state
    chk(out_valid == 1'b0, "R13", "out_valid after reset", {31'd0, out_valid}, 32'd0);
    chk(in_ready == 1'b1, "R13", "in_ready after reset", {31'd0, in_ready}, 32'd1);

    for (int i = 0; i < NV; i++) begin
      logic [124:0] v;
      v = VEC[i];
      send(v[124], {v[123:118], v[117:113], v[112:108]}, v[107:76]);
      chk(out_valid == 1'b1, VREQ[i], "out_valid", {31'd0, out_valid}, 32'd1);
      chk(out_class == v[75:69], VREQ[i], "class", {25'd0, out_class}, {25'd0, v[75:69]});
      chk(out_ra == v[117:113] && out_rb == v[112:108], VREQ[i], "fields R1",
          {22'd0, out_ra, out_rb}, {22'd0, v[117:113], v[112:108]});
      chk(out_imm == v[68:37], VREQ[i], "imm", out_imm, v[68:37]);
      chk(out_cond == v[36:32], VREQ[i], "cond", {27'd0, out_cond}, {27'd0, v[36:32]});
      chk(out_target == v[31:0], VREQ[i], "target", out_target, v[31:0]);
    end

    // R8 R12: move-immediate gathered while the consumer stalls
    send(1'b0, {6'd38, 5'd0, 5'd9}, 32'h40);
    out_ready = 1'b0;
    chk(in_ready == 1'b1, "R12", "in_ready gathering lo", {31'd0, in_ready}, 32'd1);
    chk(out_valid == 1'b0, "R8", "no record after opcode", {31'd0, out_valid}, 32'd0);
    send(1'b0, 16'h5678, 32'h42);
    chk(in_ready == 1'b1, "R12", "in_ready gathering hi", {31'd0, in_ready}, 32'd1);
    chk(out_valid == 1'b0, "R12", "no record after lo word", {31'd0, out_valid}, 32'd0);
    send(1'b0, 16'h1234, 32'h44);
    chk(out_valid == 1'b1, "R8", "record after hi word", {31'd0, out_valid}, 32'd1);
    chk(out_class == 7'd38, "R8", "movei class", {25'd0, out_class}, 32'd38);
    chk(out_imm == 32'h12345678, "R8", "movei imm", out_imm, 32'h12345678);
    chk(out_rb == 5'd9, "R8", "movei dest", {27'd0, out_rb}, 32'd9);

    // R11 held record under stall
    @(negedge clk);
    @(negedge clk);
    chk(out_valid == 1'b1 && out_imm == 32'h12345678, "R11", "held record",
        out_imm, 32'h12345678);
    chk(in_ready == 1'b0, "R11", "in_ready while full", {31'd0, in_ready}, 32'd0);
    out_ready = 1'b1;
    @(negedge clk);
    chk(out_valid == 1'b0, "R11", "presented once", {31'd0, out_valid}, 32'd0);

    // R13: reset in the middle of a gather
    send(1'b0, {6'd38, 5'd0, 5'd3}, 32'h80);
    send(1'b0, 16'hAAAA, 32'h82);
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk(out_valid == 1'b0 && in_ready == 1'b1, "R13", "cleared mid gather",
        {30'd0, out_valid, in_ready}, 32'd1);
    send(1'b0, {6'd2, 5'd4, 5'd1}, 32'h90);
    chk(out_valid == 1'b1 && out_class == 7'd2, "R13", "next word is opcode",
        {25'd0, out_class}, 32'd2);
    chk(out_imm == 32'd4, "R13", "fresh quick imm", out_imm, 32'd4);

    @(negedge clk);
    finish_run();
  end
endmodule